// File: doc/BRIEF.md
# Dual-Port Register File with Sequenced Clear

This block is a small storage array with two ports that work at the same time. Writes are captured on the rising clock edge. Reads are combinational: the read data follows the read address with no clock in between. Each port has its own address. When a write and a read hit the same word in the same cycle, an address comparator routes the incoming write data to the read output. The read therefore returns the value being written, as if the write had been done first.

Each data bit is held in a pair of adjacent column banks. The lowest address bit picks one bank of the pair for both reads and writes, and the remaining address bits pick the row. A single-cycle request starts an internally timed clear. The clear zeroes the array a few rows at a time over a fixed number of clock cycles, so the whole array is never written in one cycle. While the clear runs, a busy flag is high and writes are dropped. Reads stay available during the clear and show each word's old value until its row has been cleared.

Top module: `dualport_rf_seqclr`

## Requirements
- R1: When `we` is high and `busy` is low at a rising edge of `clk`, `wdata` is stored at word `waddr`. The word keeps that value until it is written again or cleared.
- R2: `rdata` follows the word at `raddr` combinationally, in the same cycle. `raddr` and `waddr` are independent.
- R3: If `we` is high, `busy` is low and `waddr` equals `raddr` in the same cycle, `rdata` equals `wdata` in that cycle (write-then-read ordering).
- R4: A one-cycle `clr_start` while idle raises `busy` at the next rising edge. `busy` then stays high for exactly 16 cycles (CLR_STEPS) and falls by itself.
- R5: In step k of the clear (k = 0 for the first busy cycle), the words k*(WORDS/CLR_STEPS) up to k*(WORDS/CLR_STEPS)+WORDS/CLR_STEPS-1 are zeroed at the edge that ends the step. With the defaults this is words 4k to 4k+3. After the clear, every word reads 0.
- R6: A write issued while `busy` is high is ignored. The addressed word keeps its previous or cleared value.
- R7: During the clear, reading a word that has not yet been cleared returns its old contents. Reading a word that has already been cleared returns 0.
- R8: Address bit 0 selects the column bank (1 = left, 0 = right), and the upper address bits select the row. Words that differ only in bit 0 are stored separately and never disturb each other.
- R9: A `clr_start` pulse while `busy` is high is ignored. The running clear neither restarts nor gets longer.
- R10: Driving `rst_n` low forces `busy` low at once and stops any clear in progress. Words already cleared stay zero, and the rest keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and clear steps happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the clear sequencer |
| clr_start | input | 1 | One-cycle request to start the sequenced clear |
| busy | output | 1 | High while the clear sequence runs |
| we | input | 1 | Write enable |
| waddr | input | 6 | Write word address |
| wdata | input | 16 | Write data |
| raddr | input | 6 | Read word address |
| rdata | output | 16 | Read data (combinational) |

## Verification
The assertions assume that the inputs are stable around the rising edge. They also assume that the array has been through one full clear before any read value is relied on, because the storage has no power-on value. The stimulus first performs a complete clear and compares read data only after it. It changes every input just after the falling edge. Writes during the clear, a second start request and a reset that cuts a clear short are all issued on purpose, so that the ignore and abort rules are exercised.

// File: rtl/rf_seq_pkg.sv
package rf_seq_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   function automatic int safe_log2(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rf_clear_seq.sv
module rf_clear_seq
   import rf_seq_pkg::*;
#(
   parameter int STEPS  = 16,
   parameter int STEP_W = safe_log2(STEPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic [STEP_W-1:0] step
);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

   seq_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         step  <= '0;
      end else begin
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state <= SEQ_RUN;
                  step  <= '0;
               end
            end
            default: begin
               if (step == LAST) begin
                  state <= SEQ_IDLE;
                  step  <= '0;
               end else begin
                  step <= step + 1'b1;
               end
            end
         endcase
      end
   end

   assign busy = (state == SEQ_RUN);

   assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && step == '0));

   assert_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step == LAST) |=> !busy);

   assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && step != LAST) |=> (busy && step == STEP_W'($past(step) + 1'b1)));
endmodule

// File: rtl/rf_column_bank.sv
module rf_column_bank #(
   parameter int ROWS     = 32,
   parameter int WIDTH    = 16,
   parameter int CLR_ROWS = 2,
   parameter int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ROW_W-1:0] wr_row,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             clr_en,
   input  logic [ROW_W-1:0] clr_base,
   input  logic [ROW_W-1:0] rd_row,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] cells [ROWS];

   always_ff @(posedge clk) begin
      if (clr_en) begin
         for (int r = 0; r < CLR_ROWS; r++) begin
            cells[clr_base + ROW_W'(r)] <= '0;
         end
      end else if (wr_en) begin
         cells[wr_row] <= wr_data;
      end
   end

   assign rd_data = cells[rd_row];

   assert_row_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> (cells[$past(clr_base)] == '0));

   assert_row_written_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr_en) |=> (cells[$past(wr_row)] == $past(wr_data)));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !clr_en) |=> (cells[$past(rd_row)] == $past(rd_data)));
endmodule

// File: rtl/rf_addr_match.sv
module rf_addr_match #(
   parameter int AW     = 6,
   parameter int WIDTH  = 16,
   parameter bit BYPASS = 1'b1
) (
   input  logic             wr_ok,
   input  logic [AW-1:0]    waddr,
   input  logic [AW-1:0]    raddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] array_q,
   output logic [WIDTH-1:0] rd_q
);
   generate
      if (BYPASS) begin : g_fwd
         logic hit;
         assign hit  = wr_ok && (waddr == raddr);
         assign rd_q = hit ? wdata : array_q;
      end else begin : g_plain
         assign rd_q = array_q;
      end
   endgenerate
endmodule

// File: rtl/dualport_rf_seqclr.sv
module dualport_rf_seqclr
   import rf_seq_pkg::*;
#(
   parameter int WORDS     = 64,
   parameter int WIDTH     = 16,
   parameter int CLR_STEPS = 16,
   parameter bit RD_BYPASS = 1'b1,
   parameter int AW        = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_start,
   output logic             busy,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   localparam int ROWS     = WORDS / 2;
   localparam int ROW_W    = AW - 1;
   localparam int CLR_ROWS = ROWS / CLR_STEPS;
   localparam int STEP_W   = safe_log2(CLR_STEPS);

   generate
      if (WORDS < 4 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("WORDS must be a power of two, at least 4");
      end
      if (CLR_STEPS < 1 || (ROWS % CLR_STEPS) != 0) begin : g_bad_steps
         $error("CLR_STEPS must divide WORDS/2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("WIDTH must be positive");
      end
   endgenerate

   logic              wr_ok;
   logic [STEP_W-1:0] step;
   logic [ROW_W-1:0]  clr_base;
   logic [WIDTH-1:0]  bank_q [2];
   logic [WIDTH-1:0]  array_q;

   rf_clear_seq #(
      .STEPS  (CLR_STEPS),
      .STEP_W (STEP_W)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (clr_start),
      .busy  (busy),
      .step  (step)
   );

   assign wr_ok    = we && !busy;
   assign clr_base = ROW_W'(int'(step) * CLR_ROWS);

   // bank 1 = left column (address bit 0 high), bank 0 = right column
   generate
      for (genvar b = 0; b < 2; b++) begin : g_bank
         logic bank_we;
         assign bank_we = wr_ok && (waddr[0] == 1'(b));
         rf_column_bank #(
            .ROWS     (ROWS),
            .WIDTH    (WIDTH),
            .CLR_ROWS (CLR_ROWS),
            .ROW_W    (ROW_W)
         ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_we),
            .wr_row   (waddr[AW-1:1]),
            .wr_data  (wdata),
            .clr_en   (busy),
            .clr_base (clr_base),
            .rd_row   (raddr[AW-1:1]),
            .rd_data  (bank_q[b])
         );
      end
   endgenerate

   assign array_q = raddr[0] ? bank_q[1] : bank_q[0];

   rf_addr_match #(
      .AW     (AW),
      .WIDTH  (WIDTH),
      .BYPASS (RD_BYPASS)
   ) u_match (
      .wr_ok   (wr_ok),
      .waddr   (waddr),
      .raddr   (raddr),
      .wdata   (wdata),
      .array_q (array_q),
      .rd_q    (rdata)
   );

   generate
      if (RD_BYPASS) begin : g_chk_fwd
         assert_same_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !busy && waddr == raddr) |-> (rdata == wdata));
      end
   endgenerate

   assert_write_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !busy) |=> ((raddr != $past(waddr)) || (we && !busy && waddr == raddr)
                         || (rdata == $past(wdata))));

   assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && we && !$past(busy)) |=> busy);
endmodule

// File: tb/sim_dualport_rf_seqclr.sv
module sim_dualport_rf_seqclr;
   localparam int WORDS = 64;
   localparam int WIDTH = 16;
   localparam int STEPS = 16;
   localparam int GRP   = WORDS / STEPS;

   typedef struct {
      bit               is_busy;
      logic [WIDTH-1:0] exp;
      string            tag;
   } item_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clr_start = 1'b0;
   logic             busy;
   logic             we = 1'b0;
   logic [5:0]       waddr = '0;
   logic [WIDTH-1:0] wdata = '0;
   logic [5:0]       raddr = '0;
   logic [WIDTH-1:0] rdata;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   item_t q[$];
   logic [WIDTH-1:0] model [WORDS];
   bit busy_m = 1'b0;
   int step_m = 0;

   always #5 clk = ~clk;

   dualport_rf_seqclr u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_start (clr_start),
      .busy      (busy),
      .we        (we),
      .waddr     (waddr),
      .wdata     (wdata),
      .raddr     (raddr),
      .rdata     (rdata)
   );

   // monitor: compares everything the driver queued for this cycle
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (it.is_busy) begin
               if (busy !== it.exp[0]) begin
                  errors++;
                  $display("FAIL %s busy: got %b expected %b", it.tag, busy, it.exp[0]);
               end
            end else if (rdata !== it.exp) begin
               errors++;
               $display("FAIL %s rdata: got %h expected %h", it.tag, rdata, it.exp);
            end
         end
      end
   end

   // driver: one cycle of stimulus plus expected values from the model
   task automatic cyc(input bit w, input int wa, input logic [WIDTH-1:0] wd,
                      input int ra, input bit st, input bit chk_rd, input string tag);
      item_t it;
      @(negedge clk);
      we        = w;
      waddr     = 6'(wa);
      wdata     = wd;
      raddr     = 6'(ra);
      clr_start = st;
      it.is_busy = 1'b1;
      it.exp     = WIDTH'(busy_m);
      it.tag     = tag;
      q.push_back(it);
      if (chk_rd) begin
         it.is_busy = 1'b0;
         it.exp     = (w && !busy_m && wa == ra) ? wd : model[ra];
         q.push_back(it);
      end
      // effect of the coming rising edge
      if (busy_m) begin
         for (int k = 0; k < GRP; k++) model[step_m * GRP + k] = '0;
         step_m++;
         if (step_m == STEPS) begin
            busy_m = 1'b0;
            step_m = 0;
         end
      end else begin
         if (w) model[wa] = wd;
         if (st) begin
            busy_m = 1'b1;
            step_m = 0;
         end
      end
   endtask

   function automatic logic [WIDTH-1:0] pat(input int i);
      return WIDTH'(i * 613 + 16'h1234);
   endfunction

   initial begin
      item_t it;
      for (int i = 0; i < WORDS; i++) model[i] = 'x;
      #12;
      // R10: busy low under reset
      it.is_busy = 1'b1; it.exp = '0; it.tag = "R10 reset";
      q.push_back(it);
      @(negedge clk);
      rst_n = 1'b1;

      // first clear: R4 busy length; storage unknown before, no read checks
      cyc(0, 0, '0, 0, 1, 0, "R4 start");
      for (int i = 0; i < STEPS; i++) cyc(0, 0, '0, 0, 0, 0, "R4 busy window");
      cyc(0, 0, '0, 0, 0, 0, "R4 busy fell");
      for (int i = 0; i < WORDS; i += 7) cyc(0, 0, '0, i, 0, 1, "R5 all zero");

      // R1/R2: fill array, reading the previously written word each cycle
      for (int i = 0; i < WORDS; i++)
         cyc(1, i, pat(i), (i + WORDS - 1) % WORDS, 0, 1, "R1 R2 write/read");
      // R8: adjacent words are independent
      for (int i = 0; i < WORDS; i++) cyc(0, 0, '0, i, 0, 1, "R8 bank readback");
      cyc(1, 11, 16'hBEEF, 10, 0, 1, "R8 neighbour write");
      cyc(0, 0, '0, 10, 0, 1, "R8 neighbour kept");
      cyc(0, 0, '0, 11, 0, 1, "R8 left bank");

      // R3: same-word read/write
      cyc(1, 20, 16'h5A5A, 20, 0, 1, "R3 bypass");
      cyc(1, 21, 16'hC3C3, 20, 0, 1, "R3 other word");
      cyc(1, 21, 16'h0F0F, 21, 0, 1, "R3 bypass odd");

      // second clear with reads, a write and a restart request while busy
      cyc(0, 0, '0, 63, 1, 1, "R4 start again");
      for (int i = 0; i < STEPS; i++) begin
         if (i == 3)
            cyc(1, 2, 16'hFFFF, 2, 0, 1, "R6 write while busy");
         else if (i == 5)
            cyc(0, 0, '0, 62, 1, 1, "R9 start while busy");
         else if (i % 2 == 0)
            cyc(0, 0, '0, 63, 0, 1, "R7 old before clear");
         else
            cyc(0, 0, '0, (i - 1) * GRP, 0, 1, "R7 zero after clear");
      end
      cyc(0, 0, '0, 63, 0, 1, "R9 ends on time");
      for (int i = 0; i < WORDS; i += 3) cyc(0, 0, '0, i, 0, 1, "R5 R6 zero after");

      // R10: reset in the middle of a clear
      for (int i = 0; i < WORDS; i++) cyc(1, i, pat(i + 5), 0, 0, 0, "R1 refill");
      cyc(0, 0, '0, 0, 1, 0, "R10 start");
      for (int i = 0; i < 3; i++) cyc(0, 0, '0, 0, 0, 0, "R10 run");
      @(negedge clk);
      rst_n = 1'b0;
      busy_m = 1'b0;
      step_m = 0;
      it.is_busy = 1'b1; it.exp = '0; it.tag = "R10 abort";
      q.push_back(it);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 20; i++) cyc(0, 0, '0, i, 0, 1, "R10 partial clear");
      cyc(0, 0, '0, 0, 0, 0, "R10 idle");

      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule